// File: doc/BRIEF.md
# Memory Serialization Reference Checker

This block is a hardware reference model that assembles one global order of memory operations and checks the order while it is being built. An agent announces an operation (issuing location, kind, word address, data) through the create port and gets back a stamp. Later the agent commits that stamp. The commit is accepted only when every earlier operation that must precede it has already committed. Finally the agent evaluates the stamp and receives the value the operation produces within the commit order.

Internally the block keeps a table of outstanding stamps, a record of predecessors for each entry, and a shadow memory. The shadow memory changes only at commit time. Read results therefore follow the order in which operations committed, not the order in which they were created.

Operation X must precede operation Y when all of the following hold:
- both come from the same location;
- X was created before Y;
- they use the same address, or at least one of them is atomic.

Rule violations appear on three error pins. Each pin pulses for one cycle.

All three request ports use valid/ready. A create is accepted in a cycle where `crt_valid` and `crt_ready` are both high. `crt_ready` drops only while the stamp table is full. Commit and eval never apply back-pressure: their ready outputs are held high, and the block processes at most one commit and one eval per cycle. The result of an eval is a one-cycle `res_valid` pulse with no ready, so a consumer must take it in that cycle.

Top module: `memser_refchk`

## Requirements
- R1: After reset, `crt_ready`=1, `tbl_full`=0, `res_valid`=0 and all error pins are 0. All 64 shadow words read as zero.
- R2: When a create is accepted, `crt_stamp` shows the lowest-numbered free table entry in that same cycle, and that number becomes the stamp.
- R3: The table holds 16 stamps. When all 16 are outstanding, `tbl_full`=1 and `crt_ready`=0, and `crt_valid` has no effect. An entry becomes free again after a successful eval of its stamp.
- R4: A commit is refused when an uncommitted entry exists that satisfies all of the following:
  - it comes from the same location;
  - it was created earlier;
  - it has the same address, or either operation is atomic.
  A refused commit pulses `err_order` in the next cycle and changes no state, so the commit can be retried later.
- R5: Operations from different locations, or non-atomic operations to different addresses, may commit in any order without an error.
- R6: Kind encoding: 2'b00 is read, 2'b01 is write, 2'b10 is atomic swap, and 2'b11 behaves as a read. A committed write updates the shadow word in its commit cycle. A read returns the value of the most recently committed write to its address.
- R7: A committed atomic swap returns the old word and stores its own data into that word in the same cycle.
- R8: An eval of an allocated but uncommitted stamp pulses `err_uncommitted` in the next cycle. The entry stays allocated.
- R9: A commit or eval of a stamp that is not allocated, or a second commit of the same stamp, pulses `err_bad_stamp` in the next cycle.
- R10: A successful eval drives `res_valid` high for one cycle, in the cycle after the eval. `res_stamp` and `res_data` carry the stamp and its value.
- R11: An eval of a write returns the data that the write carried.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| crt_valid | input | 1 | Create request valid |
| crt_ready | output | 1 | Create can be accepted (table not full) |
| crt_loc | input | 2 | Issuing location |
| crt_kind | input | 2 | Operation kind |
| crt_addr | input | 6 | Word address |
| crt_data | input | 16 | Write or swap data |
| crt_stamp | output | 4 | Stamp assigned by an accepted create |
| tbl_full | output | 1 | All stamp entries are outstanding |
| cmt_valid | input | 1 | Commit request valid |
| cmt_ready | output | 1 | Commit ready (always 1) |
| cmt_stamp | input | 4 | Stamp to commit |
| evl_valid | input | 1 | Eval request valid |
| evl_ready | output | 1 | Eval ready (always 1) |
| evl_stamp | input | 4 | Stamp to evaluate |
| res_valid | output | 1 | Eval result valid |
| res_stamp | output | 4 | Stamp of the result |
| res_data | output | 16 | Value of the operation |
| err_order | output | 1 | Commit refused because a predecessor is still uncommitted |
| err_bad_stamp | output | 1 | Commit or eval of an unallocated stamp, or a repeated commit |
| err_uncommitted | output | 1 | Eval of an uncommitted stamp |

## Verification
The bench commits writes from two locations to one address in the reverse of their issue order. This separates commit-order memory update from issue-order update. Same-location pairs are committed out of order in two forms:
- same address;
- different addresses with one atomic operation.

Both must fail, which shows that the predecessor rule covers both its address clause and its atomic clause. A same-location pair to different addresses with no atomic operation must pass. Filling all sixteen entries, then freeing one from the middle, shows that allocation picks the lowest free slot and that create is blocked while the table is full.

// File: rtl/sref_pkg.sv
package sref_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'b00,
    OP_WRITE = 2'b01,
    OP_SWAP  = 2'b10,
    OP_RSVD  = 2'b11
  } op_kind_e;
endpackage

// File: rtl/sref_lowfree.sv
// Lowest-index free slot finder.
module sref_lowfree #(
  parameter int N  = 16,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  busy,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!busy[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/sref_shadow.sv
// Shadow memory, written in commit order, reset to zero.
module sref_shadow #(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] words [DEPTH];

  assign rd_data = words[rd_addr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) words[i] <= '0;
    end else if (wr_en) begin
      words[wr_addr] <= wr_data;
    end
  end
endmodule

// File: rtl/sref_stamp_table.sv
// Outstanding stamp entries with a predecessor matrix.
module sref_stamp_table
  import sref_pkg::*;
#(
  parameter int N  = 16,
  parameter int LW = 2,
  parameter int AW = 6,
  parameter int DW = 16,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_en,
  input  logic [LW-1:0] alloc_loc,
  input  logic [1:0]    alloc_kind,
  input  logic [AW-1:0] alloc_addr,
  input  logic [DW-1:0] alloc_data,
  output logic [IW-1:0] alloc_idx,
  output logic          full,
  input  logic          cmt_en,
  input  logic [IW-1:0] cmt_idx,
  input  logic [DW-1:0] cmt_result,
  output logic          c_vld,
  output logic          c_done,
  output logic          c_pend,
  output logic [1:0]    c_kind,
  output logic [AW-1:0] c_addr,
  output logic [DW-1:0] c_data,
  input  logic          free_en,
  input  logic [IW-1:0] evl_idx,
  output logic          e_vld,
  output logic          e_done,
  output logic [DW-1:0] e_data
);
  logic [N-1:0]  vld, done;
  logic [LW-1:0] loc_q  [N];
  logic [1:0]    kind_q [N];
  logic [AW-1:0] addr_q [N];
  logic [DW-1:0] data_q [N];
  logic [N-1:0]  pred   [N];
  logic [N-1:0]  hb_new, clr;
  logic          found;

  sref_lowfree #(.N(N), .IW(IW)) u_free (
    .busy (vld),
    .found(found),
    .idx  (alloc_idx)
  );
  assign full = !found;

  // Earlier uncommitted entries that the new operation must follow.
  always_comb begin
    for (int j = 0; j < N; j++) begin
      hb_new[j] = vld[j] && !done[j] && (loc_q[j] == alloc_loc) &&
                  ((addr_q[j] == alloc_addr) || (kind_q[j] == OP_SWAP) ||
                   (alloc_kind == OP_SWAP));
    end
    clr = cmt_en ? ({{(N-1){1'b0}}, 1'b1} << cmt_idx) : '0;
  end

  assign c_vld  = vld[cmt_idx];
  assign c_done = done[cmt_idx];
  assign c_pend = |pred[cmt_idx];
  assign c_kind = kind_q[cmt_idx];
  assign c_addr = addr_q[cmt_idx];
  assign c_data = data_q[cmt_idx];
  assign e_vld  = vld[evl_idx];
  assign e_done = done[evl_idx];
  assign e_data = data_q[evl_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld  <= '0;
      done <= '0;
      for (int i = 0; i < N; i++) begin
        pred[i]   <= '0;
        loc_q[i]  <= '0;
        kind_q[i] <= '0;
        addr_q[i] <= '0;
        data_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < N; i++) begin
        pred[i] <= pred[i] & ~clr;
        if (alloc_en && alloc_idx == IW'(i)) begin
          vld[i]    <= 1'b1;
          done[i]   <= 1'b0;
          pred[i]   <= hb_new & ~clr;
          loc_q[i]  <= alloc_loc;
          kind_q[i] <= alloc_kind;
          addr_q[i] <= alloc_addr;
          data_q[i] <= alloc_data;
        end
        if (cmt_en && cmt_idx == IW'(i)) begin
          done[i]   <= 1'b1;
          data_q[i] <= cmt_result;
        end
        if (free_en && evl_idx == IW'(i)) begin
          vld[i] <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/memser_refchk.sv
module memser_refchk
  import sref_pkg::*;
#(
  parameter int N_ENT  = 16,
  parameter int LOC_W  = 2,
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16,
  localparam int SW    = $clog2(N_ENT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              crt_valid,
  output logic              crt_ready,
  input  logic [LOC_W-1:0]  crt_loc,
  input  logic [1:0]        crt_kind,
  input  logic [ADDR_W-1:0] crt_addr,
  input  logic [DATA_W-1:0] crt_data,
  output logic [SW-1:0]     crt_stamp,
  output logic              tbl_full,
  input  logic              cmt_valid,
  output logic              cmt_ready,
  input  logic [SW-1:0]     cmt_stamp,
  input  logic              evl_valid,
  output logic              evl_ready,
  input  logic [SW-1:0]     evl_stamp,
  output logic              res_valid,
  output logic [SW-1:0]     res_stamp,
  output logic [DATA_W-1:0] res_data,
  output logic              err_order,
  output logic              err_bad_stamp,
  output logic              err_uncommitted
);
  logic              full, alloc_en;
  logic              c_vld, c_done, c_pend, e_vld, e_done;
  logic [1:0]        c_kind;
  logic [ADDR_W-1:0] c_addr;
  logic [DATA_W-1:0] c_data, e_data, mem_rd, cmt_res;
  logic              cmt_bad, cmt_blk, cmt_ok, cmt_wr;
  logic              ev_bad, ev_unc, ev_ok;

  assign crt_ready = !full;
  assign tbl_full  = full;
  assign cmt_ready = 1'b1;
  assign evl_ready = 1'b1;
  assign alloc_en  = crt_valid && !full;

  // Commit decision
  assign cmt_bad = cmt_valid && (!c_vld || c_done);
  assign cmt_blk = cmt_valid && c_vld && !c_done && c_pend;
  assign cmt_ok  = cmt_valid && c_vld && !c_done && !c_pend;
  assign cmt_wr  = cmt_ok && (c_kind == OP_WRITE || c_kind == OP_SWAP);
  assign cmt_res = (c_kind == OP_WRITE) ? c_data : mem_rd;

  // Eval decision
  assign ev_bad = evl_valid && !e_vld;
  assign ev_unc = evl_valid && e_vld && !e_done;
  assign ev_ok  = evl_valid && e_vld && e_done;

  sref_stamp_table #(
    .N(N_ENT), .LW(LOC_W), .AW(ADDR_W), .DW(DATA_W), .IW(SW)
  ) u_tbl (
    .clk       (clk),
    .rst_n     (rst_n),
    .alloc_en  (alloc_en),
    .alloc_loc (crt_loc),
    .alloc_kind(crt_kind),
    .alloc_addr(crt_addr),
    .alloc_data(crt_data),
    .alloc_idx (crt_stamp),
    .full      (full),
    .cmt_en    (cmt_ok),
    .cmt_idx   (cmt_stamp),
    .cmt_result(cmt_res),
    .c_vld     (c_vld),
    .c_done    (c_done),
    .c_pend    (c_pend),
    .c_kind    (c_kind),
    .c_addr    (c_addr),
    .c_data    (c_data),
    .free_en   (ev_ok),
    .evl_idx   (evl_stamp),
    .e_vld     (e_vld),
    .e_done    (e_done),
    .e_data    (e_data)
  );

  sref_shadow #(.AW(ADDR_W), .DW(DATA_W)) u_mem (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_addr(c_addr),
    .rd_data(mem_rd),
    .wr_en  (cmt_wr),
    .wr_addr(c_addr),
    .wr_data(c_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid       <= 1'b0;
      res_stamp       <= '0;
      res_data        <= '0;
      err_order       <= 1'b0;
      err_bad_stamp   <= 1'b0;
      err_uncommitted <= 1'b0;
    end else begin
      res_valid       <= ev_ok;
      err_order       <= cmt_blk;
      err_bad_stamp   <= cmt_bad || ev_bad;
      err_uncommitted <= ev_unc;
      if (ev_ok) begin
        res_stamp <= evl_stamp;
        res_data  <= e_data;
      end
    end
  end
endmodule

// File: rtl/memser_refchk_sva.sv
module memser_refchk_sva (
  input logic clk,
  input logic rst_n,
  input logic crt_valid,
  input logic tbl_full,
  input logic cmt_valid,
  input logic evl_valid,
  input logic res_valid,
  input logic err_order,
  input logic err_bad_stamp,
  input logic err_uncommitted
);
  assert_full_after_create_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tbl_full) |-> $past(crt_valid));

  assert_order_err_from_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    err_order |-> $past(cmt_valid));

  assert_unc_err_no_result_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_uncommitted |-> ($past(evl_valid) && !res_valid));

  assert_bad_err_from_request_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err_bad_stamp |-> $past(cmt_valid || evl_valid));

  assert_result_follows_eval_R10: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(evl_valid));
endmodule

bind memser_refchk memser_refchk_sva u_sva (.*);

// File: tb/memser_refchk_tb.sv
module memser_refchk_tb;
  localparam int C_RES = 0, C_ORD = 1, C_BAD = 2, C_UNC = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        crt_valid = 1'b0, cmt_valid = 1'b0, evl_valid = 1'b0;
  logic [1:0]  crt_loc = '0, crt_kind = '0;
  logic [5:0]  crt_addr = '0;
  logic [15:0] crt_data = '0;
  logic [3:0]  cmt_stamp = '0, evl_stamp = '0;
  logic        crt_ready, tbl_full, cmt_ready, evl_ready, res_valid;
  logic        err_order, err_bad_stamp, err_uncommitted;
  logic [3:0]  crt_stamp, res_stamp;
  logic [15:0] res_data;

  int checks = 0, errors = 0;
  bit finished = 0;

  int          q_code[$];
  logic [15:0] q_data[$];
  logic [3:0]  q_stamp[$];
  string       q_tag[$];

  always #5 clk = ~clk;

  memser_refchk u_dut (.*);

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic push(input int code, input logic [15:0] d, input logic [3:0] s,
                      input string tag);
    q_code.push_back(code); q_data.push_back(d);
    q_stamp.push_back(s);   q_tag.push_back(tag);
  endtask

  // Driver tasks: entered just after a rising edge.
  task automatic do_create(input logic [1:0] loc, input logic [1:0] kind,
                           input logic [5:0] addr, input logic [15:0] d,
                           input logic [3:0] exp_stamp, input string tag,
                           output logic [3:0] stamp);
    crt_valid = 1'b1; crt_loc = loc; crt_kind = kind; crt_addr = addr; crt_data = d;
    @(negedge clk);
    chk(crt_ready == 1'b1, tag, "crt_ready", crt_ready, 1);
    chk(crt_stamp == exp_stamp, tag, "crt_stamp", crt_stamp, exp_stamp);
    stamp = crt_stamp;
    @(posedge clk); #1;
    crt_valid = 1'b0;
  endtask

  task automatic do_commit(input logic [3:0] s, input int code, input string tag);
    if (code >= 0) push(code, '0, '0, tag);
    cmt_valid = 1'b1; cmt_stamp = s;
    @(posedge clk); #1;
    cmt_valid = 1'b0;
  endtask

  task automatic do_eval(input logic [3:0] s, input int code, input logic [15:0] d,
                         input string tag);
    push(code, d, s, tag);
    evl_valid = 1'b1; evl_stamp = s;
    @(posedge clk); #1;
    evl_valid = 1'b0;
  endtask

  // Monitor: pops expected events and compares.
  always @(negedge clk) begin
    if (rst_n && (res_valid || err_order || err_bad_stamp || err_uncommitted)) begin
      int got;
      got = res_valid ? C_RES : err_order ? C_ORD : err_bad_stamp ? C_BAD : C_UNC;
      if (q_code.size() == 0) begin
        chk(1'b0, "R4/R8/R9/R10", "unexpected event", got, -1);
      end else begin
        int code; logic [15:0] d; logic [3:0] s; string tag;
        code = q_code.pop_front(); d = q_data.pop_front();
        s = q_stamp.pop_front();   tag = q_tag.pop_front();
        chk(got == code, tag, "event kind", got, code);
        if (code == C_RES && got == C_RES) begin
          chk(res_data == d, tag, "res_data", res_data, d);
          chk(res_stamp == s, {tag, " R10"}, "res_stamp", res_stamp, s);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "WATCHDOG", "timeout", 0, 1);
    finish_run();
  end

  initial begin
    logic [3:0] s0, s1, s2, t;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(crt_ready == 1 && tbl_full == 0, "R1", "ready/full", {crt_ready, tbl_full}, 2'b10);
    chk(!res_valid && !err_order && !err_bad_stamp && !err_uncommitted, "R1",
        "outputs idle", {res_valid, err_order, err_bad_stamp, err_uncommitted}, 0);
    @(posedge clk); #1;

    // R1: untouched word reads zero
    do_create(2'd0, 2'b00, 6'd5, 16'h0, 4'd0, "R2", s0);
    do_commit(s0, -1, "R1");
    do_eval(s0, C_RES, 16'h0000, "R1");

    // R6/R11: cross-location write then read
    do_create(2'd0, 2'b01, 6'd3, 16'h1111, 4'd0, "R2", s0);
    do_create(2'd1, 2'b00, 6'd3, 16'h0, 4'd1, "R2", s1);
    do_commit(s0, -1, "R5");
    do_commit(s1, -1, "R5");
    do_eval(s1, C_RES, 16'h1111, "R6");
    do_eval(s0, C_RES, 16'h1111, "R11");

    // R6: commit order decides the read value, not issue order
    do_create(2'd0, 2'b01, 6'd7, 16'hAAAA, 4'd0, "R2", s0);
    do_create(2'd1, 2'b01, 6'd7, 16'hBBBB, 4'd1, "R2", s1);
    do_create(2'd2, 2'b00, 6'd7, 16'h0, 4'd2, "R2", s2);
    do_commit(s1, -1, "R5");
    do_commit(s0, -1, "R5");
    do_commit(s2, -1, "R6");
    do_eval(s2, C_RES, 16'hAAAA, "R6");
    do_eval(s0, C_RES, 16'hAAAA, "R11");
    do_eval(s1, C_RES, 16'hBBBB, "R11");

    // R4: same location, same address, out of order
    do_create(2'd0, 2'b01, 6'd9, 16'h1234, 4'd0, "R2", s0);
    do_create(2'd0, 2'b00, 6'd9, 16'h0, 4'd1, "R2", s1);
    do_commit(s1, C_ORD, "R4");
    do_commit(s0, -1, "R4");
    do_commit(s1, -1, "R4");
    do_eval(s1, C_RES, 16'h1234, "R4");
    do_eval(s0, C_RES, 16'h1234, "R11");

    // R4/R7: atomic against a different address, same location
    do_create(2'd0, 2'b01, 6'd10, 16'h0005, 4'd0, "R2", s0);
    do_create(2'd0, 2'b10, 6'd11, 16'h0009, 4'd1, "R2", s1);
    do_commit(s1, C_ORD, "R4");
    do_commit(s0, -1, "R4");
    do_commit(s1, -1, "R7");
    do_eval(s1, C_RES, 16'h0000, "R7");
    do_create(2'd3, 2'b00, 6'd11, 16'h0, 4'd1, "R2", s2);
    do_commit(s2, -1, "R7");
    do_eval(s2, C_RES, 16'h0009, "R7");
    do_eval(s0, C_RES, 16'h0005, "R11");

    // R5: same location, different addresses, no atomic
    do_create(2'd0, 2'b01, 6'd12, 16'h0077, 4'd0, "R2", s0);
    do_create(2'd0, 2'b01, 6'd13, 16'h0088, 4'd1, "R2", s1);
    do_commit(s1, -1, "R5");
    do_commit(s0, -1, "R5");
    do_eval(s1, C_RES, 16'h0088, "R5");
    do_eval(s0, C_RES, 16'h0077, "R5");

    // R8: eval before commit
    do_create(2'd1, 2'b00, 6'd1, 16'h0, 4'd0, "R2", s0);
    do_eval(s0, C_UNC, 16'h0, "R8");
    do_commit(s0, -1, "R8");
    do_eval(s0, C_RES, 16'h0000, "R8");

    // R9: unallocated stamps and a repeated commit
    do_commit(4'd15, C_BAD, "R9");
    do_eval(4'd14, C_BAD, 16'h0, "R9");
    do_create(2'd2, 2'b01, 6'd2, 16'h0042, 4'd0, "R2", s0);
    do_commit(s0, -1, "R9");
    do_commit(s0, C_BAD, "R9");
    do_eval(s0, C_RES, 16'h0042, "R9");
    do_eval(s0, C_BAD, 16'h0, "R9");

    // R3: fill the table
    for (int i = 0; i < 16; i++) begin
      do_create(2'(i % 4), 2'b00, 6'(20 + i), 16'h0, 4'(i), "R3", t);
    end
    @(negedge clk);
    chk(tbl_full == 1 && crt_ready == 0, "R3", "full flags", {tbl_full, crt_ready}, 2'b10);
    @(posedge clk); #1;
    crt_valid = 1'b1; crt_loc = 2'd0; crt_kind = 2'b01; crt_addr = 6'd20; crt_data = 16'hDEAD;
    @(posedge clk); #1;
    crt_valid = 1'b0;
    do_commit(4'd0, -1, "R3");
    do_eval(4'd0, C_RES, 16'h0000, "R3");
    do_commit(4'd5, -1, "R3");
    do_eval(4'd5, C_RES, 16'h0000, "R3");
    do_create(2'd1, 2'b00, 6'd40, 16'h0, 4'd0, "R3", t);
    do_create(2'd1, 2'b00, 6'd41, 16'h0, 4'd5, "R3", t);
    @(negedge clk);
    chk(tbl_full == 1, "R3", "full again", tbl_full, 1);

    repeat (3) @(posedge clk);
    chk(q_code.size() == 0, "R10", "pending expected events", q_code.size(), 0);
    finish_run();
  end
endmodule